// File: doc/BRIEF.md
# Programmable Interval Timer

This block divides an external event stream. A slow timer-input signal is brought into the system clock domain, and each of its rising edges steps a 14-bit down counter. At terminal count the counter either reloads or stops, depending on the selected output mode. A wave-shaping stage turns the counter state into a registered timer output. That output can be a square wave, a single low half-period, a single low pulse, or a repeating low pulse.

Software programs the block through a small byte-wide register window. Two length bytes hold the count length and the output mode. A command/status byte carries a start/stop command field when written. When read, it returns the running state and a sticky terminal-count flag. A start issued while the timer runs is held back until the current count reaches terminal count. A stop can also be deferred to that point.

Top module: `prog_interval_timer`

## Requirements
- R1: A write at offset 4 stores length bits 7:0. A write at offset 5 stores length bits 13:8 from wdata[5:0] and the mode from wdata[7:6] (00 half-low, 01 square, 10 one-shot pulse, 11 repeating pulse). A read of offset 4 or 5 returns the same layout.
- R2: tmr_in is synchronized and edge-detected. The running counter decrements once per rising edge of tmr_in and holds otherwise.
- R3: Writing command 11 (START) in wdata[7:6] at offset 0 while stopped loads the length and mode and starts counting from the length, with tmr_out high.
- R4: In mode 01, tmr_out stays high for the first ceil(N/2) input pulses of each N-pulse period and low for the rest. At terminal count the counter reloads and repeats.
- R5: Mode 00 produces one period of the R4 waveform. At terminal count the timer stops and tmr_out returns high.
- R6: In mode 10, tmr_out goes low after N-1 pulses and stays low until the Nth. The timer then stops with tmr_out high.
- R7: Mode 11 repeats the R6 low pulse every N pulses with automatic reload.
- R8: Command 01 (STOP) halts a running timer at once with tmr_out high. STOP and command 10 issued while stopped change nothing, and input pulses then leave tmr_out high.
- R9: Command 10 (STOP-AFTER-TC) lets the current count finish, then stops the timer at terminal count.
- R10: A START issued while running keeps the present mode and count until terminal count. It then loads the length and mode held in the registers at that moment.
- R11: A read of offset 0 returns, one cycle after rd_en, bit 7 = running and bit 6 = terminal-count flag, with the other bits zero. The flag, also driven on tc_flag, sets at every terminal count and clears on that read.
- R12: Reset stops the timer, drives tmr_out high and clears the flag. It keeps the stored length and mode, so a later START uses them.
- R13: A stored length below 2 is counted as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| tmr_in | input | 1 | External timer-input pulse |
| tmr_out | output | 1 | Shaped timer output, registered |
| tc_flag | output | 1 | Sticky terminal-count flag |

## Verification
The bench builds the block with a 14-bit counter and a two-stage input synchronizer, which are the defaults. The full register layout is therefore checked, including the mode bits that sit above the length in the high byte. Short lengths (1 to 6) keep every period within a few dozen input pulses. This brings odd and even split points, reload, deferred start and stop, and the clamp of the minimum length within reach in a short run.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_STOP    = 2'b01,
    CMD_STOP_TC = 2'b10,
    CMD_START   = 2'b11
  } pit_cmd_e;

  typedef enum logic [1:0] {
    MODE_HALF_LOW     = 2'b00,
    MODE_SQUARE       = 2'b01,
    MODE_ONE_PULSE    = 2'b10,
    MODE_PULSE_RELOAD = 2'b11
  } pit_mode_e;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'b00,
    PEND_STOP  = 2'b01,
    PEND_START = 2'b10
  } pit_pend_e;

endpackage

// File: rtl/pit_pulse_sync.sv
module pit_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic step
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      step_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
      step_q <= sync_q[STAGES-1] & ~prev_q;
    end
  end

  assign step = step_q;

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    step_q |=> !step_q); // R2

endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              running,
  input  logic              tc_evt,
  output logic [CNT_W-1:0]  len_cfg,
  output pit_mode_e         mode_cfg,
  output logic              cmd_wr,
  output pit_cmd_e          cmd,
  output logic [7:0]        rdata,
  output logic              tc_flag
);
  localparam logic [ADDR_W-1:0] OFS_CMD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_LO  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_HI  = ADDR_W'(5);
  localparam int HI_BITS = CNT_W - 8;

  logic [CNT_W-1:0] len_q;
  pit_mode_e        mode_q;
  logic             flag_q;
  logic [7:0]       rdata_q;
  logic [7:0]       hi_byte;
  logic [7:0]       rd_mux;
  logic             rd_status;

  // length and mode survive reset by intent
  always_ff @(posedge clk) begin
    if (wr_en && addr == OFS_LO) len_q[7:0] <= wdata;
    if (wr_en && addr == OFS_HI) begin
      len_q[CNT_W-1:8] <= wdata[HI_BITS-1:0];
      mode_q           <= pit_mode_e'(wdata[7:6]);
    end
  end

  always_comb begin
    hi_byte              = '0;
    hi_byte[7:6]         = mode_q;
    hi_byte[HI_BITS-1:0] = len_q[CNT_W-1:8];
  end

  assign rd_status = rd_en && addr == OFS_CMD;

  always_comb begin
    case (addr)
      OFS_CMD: rd_mux = {running, flag_q, 6'b0};
      OFS_LO:  rd_mux = len_q[7:0];
      OFS_HI:  rd_mux = hi_byte;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (tc_evt)         flag_q <= 1'b1;
      else if (rd_status) flag_q <= 1'b0;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign len_cfg  = len_q;
  assign mode_cfg = mode_q;
  assign cmd_wr   = wr_en && addr == OFS_CMD;
  assign cmd      = pit_cmd_e'(wdata[7:6]);
  assign rdata    = rdata_q;
  assign tc_flag  = flag_q;

  AST_TC_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    tc_evt |=> flag_q); // R11
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !tc_evt) |=> !flag_q); // R11

endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             cmd_wr,
  input  pit_cmd_e         cmd,
  input  logic [CNT_W-1:0] len_cfg,
  input  pit_mode_e        mode_cfg,
  output logic             running,
  output logic             tc_evt,
  output logic             tmr_out
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_len_q;
  pit_mode_e        act_mode_q;
  pit_pend_e        pend_q;
  logic             run_q;
  logic             tc_q;
  logic             out_q;
  logic [CNT_W-1:0] eff_len;
  logic             tc_hit;
  logic             single_mode;
  logic             wave;

  assign eff_len     = (len_cfg < MIN_LEN) ? MIN_LEN : len_cfg;
  assign tc_hit      = run_q && step && cnt_q == ONE;
  assign single_mode = act_mode_q == MODE_HALF_LOW || act_mode_q == MODE_ONE_PULSE;

  always_comb begin
    if (act_mode_q == MODE_HALF_LOW || act_mode_q == MODE_SQUARE)
      wave = cnt_q > (act_len_q >> 1);
    else
      wave = cnt_q != ONE;
  end

  // counter, active configuration and start/stop sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pend_q <= PEND_NONE;
      tc_q   <= 1'b0;
      out_q  <= 1'b1;
    end else begin
      tc_q  <= tc_hit;
      out_q <= run_q ? wave : 1'b1;
      if (run_q && step) begin
        if (cnt_q == ONE) begin
          case (pend_q)
            PEND_START: begin
              act_len_q  <= eff_len;
              act_mode_q <= mode_cfg;
              cnt_q      <= eff_len;
              pend_q     <= PEND_NONE;
            end
            PEND_STOP: begin
              run_q  <= 1'b0;
              pend_q <= PEND_NONE;
            end
            default: begin
              if (single_mode) run_q <= 1'b0;
              else             cnt_q <= act_len_q;
            end
          endcase
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
      if (cmd_wr) begin
        case (cmd)
          CMD_STOP: begin
            if (run_q) begin
              run_q  <= 1'b0;
              pend_q <= PEND_NONE;
            end
          end
          CMD_STOP_TC: begin
            if (run_q) pend_q <= PEND_STOP;
          end
          CMD_START: begin
            if (run_q) begin
              pend_q <= PEND_START;
            end else begin
              act_len_q  <= eff_len;
              act_mode_q <= mode_cfg;
              cnt_q      <= eff_len;
              run_q      <= 1'b1;
              pend_q     <= PEND_NONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign running = run_q;
  assign tc_evt  = tc_q;
  assign tmr_out = out_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0 && cnt_q <= act_len_q)); // R3
  AST_STEP_DECR: assert property (@(posedge clk) disable iff (rst)
    (run_q && step && cnt_q > ONE && !cmd_wr) |=> cnt_q == $past(cnt_q) - ONE); // R2
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && !step && !cmd_wr) |=> (run_q && $stable(cnt_q))); // R2
  AST_STOP_NOW: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd == CMD_STOP) |=> !run_q); // R8
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> out_q); // R8
  AST_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
    run_q |-> act_len_q >= MIN_LEN); // R13

endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
  import pit_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              tmr_in,
  output logic              tmr_out,
  output logic              tc_flag
);
  logic             step;
  logic             running;
  logic             tc_evt;
  logic             cmd_wr;
  pit_cmd_e         cmd;
  logic [CNT_W-1:0] len_cfg;
  pit_mode_e        mode_cfg;

  pit_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (tmr_in),
    .step (step)
  );

  pit_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .running  (running),
    .tc_evt   (tc_evt),
    .len_cfg  (len_cfg),
    .mode_cfg (mode_cfg),
    .cmd_wr   (cmd_wr),
    .cmd      (cmd),
    .rdata    (rdata),
    .tc_flag  (tc_flag)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .cmd_wr   (cmd_wr),
    .cmd      (cmd),
    .len_cfg  (len_cfg),
    .mode_cfg (mode_cfg),
    .running  (running),
    .tc_evt   (tc_evt),
    .tmr_out  (tmr_out)
  );

endmodule

// File: tb/sim_prog_interval_timer.sv
`timescale 1ns/1ps
module sim_prog_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tmr_in = 1'b0;
  logic       tmr_out;
  logic       tc_flag;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  prog_interval_timer #(.CNT_W(14), .SYNC_STAGES(2), .ADDR_W(3)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_in(tmr_in), .tmr_out(tmr_out),
    .tc_flag(tc_flag)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    cyc(3);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_len(input logic [13:0] len, input logic [1:0] mode);
    wr(3'd4, len[7:0]);
    wr(3'd5, {mode, len[13:8]});
  endtask

  task automatic command(input logic [1:0] c);
    wr(3'd0, {c, 6'b0});
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tmr_in = 1'b1; cyc(4);
      tmr_in = 1'b0; cyc(4);
    end
  endtask

  task automatic chk_status(input string req, input logic [7:0] exp);
    logic [7:0] d;
    rd(3'd0, d);
    chk(req, d, exp);
  endtask

  task automatic chk_out(input string req, input logic exp);
    chk(req, {7'b0, tmr_out}, {7'b0, exp});
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(2);
    chk_out("R12 out after reset", 1'b1);
    chk("R12 flag after reset", {7'b0, tc_flag}, 8'h00);
    chk_status("R12 status after reset", 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    set_len(14'h2A5C, 2'b10);
    rd(3'd4, d); chk("R1 low byte", d, 8'h5C);
    rd(3'd5, d); chk("R1 high byte and mode", d, 8'hAA);
    chk_status("R1 no start", 8'h00);
  endtask

  task automatic t_square;
    set_len(14'd5, 2'b01);
    command(2'b11);
    chk_out("R3 out after start", 1'b1);
    chk_status("R3 running", 8'h80);
    pulse(2); chk_out("R4 high after 2 of 5", 1'b1);
    pulse(1); chk_out("R4 low after 3 of 5", 1'b0);
    pulse(1); chk_out("R2 low after 4 of 5", 1'b0);
    pulse(1); chk_out("R4 high after reload", 1'b1);
    chk("R11 tc_flag pin", {7'b0, tc_flag}, 8'h01);
    chk_status("R11 status with flag", 8'hC0);
    chk_status("R11 flag cleared by read", 8'h80);
    pulse(3); chk_out("R4 low in second period", 1'b0);
    command(2'b01);
  endtask

  task automatic t_half_low;
    set_len(14'd5, 2'b00);
    command(2'b11);
    pulse(3); chk_out("R5 low in second half", 1'b0);
    pulse(2); chk_out("R5 high after tc", 1'b1);
    chk_status("R5 stopped after tc", 8'h40);
    pulse(3); chk_out("R5 stays high", 1'b1);
  endtask

  task automatic t_one_pulse;
    set_len(14'd4, 2'b10);
    command(2'b11);
    pulse(2); chk_out("R6 high before last", 1'b1);
    pulse(1); chk_out("R6 low on last", 1'b0);
    pulse(1); chk_out("R6 high after tc", 1'b1);
    chk_status("R6 stopped", 8'h40);
    pulse(4); chk_out("R6 no retrigger", 1'b1);
  endtask

  task automatic t_pulse_reload;
    set_len(14'd4, 2'b11);
    command(2'b11);
    pulse(3); chk_out("R7 first pulse low", 1'b0);
    pulse(1); chk_out("R7 high after tc", 1'b1);
    pulse(3); chk_out("R7 second pulse low", 1'b0);
    pulse(1); chk_out("R7 high again", 1'b1);
    chk_status("R7 still running", 8'hC0);
    command(2'b01);
  endtask

  task automatic t_stop;
    set_len(14'd4, 2'b01);
    command(2'b11);
    pulse(2); chk_out("R8 low before stop", 1'b0);
    command(2'b01);
    chk_out("R8 high after stop", 1'b1);
    chk_status("R8 stopped", 8'h00);
    command(2'b01);
    command(2'b10);
    pulse(4);
    chk_out("R8 idle stays high", 1'b1);
    chk_status("R8 idle commands ignored", 8'h00);
  endtask

  task automatic t_stop_tc;
    set_len(14'd3, 2'b01);
    command(2'b11);
    pulse(1);
    command(2'b10);
    chk_status("R9 still running", 8'h80);
    pulse(1); chk_out("R9 low before tc", 1'b0);
    pulse(1); chk_out("R9 high after tc", 1'b1);
    chk_status("R9 stopped at tc", 8'h40);
  endtask

  task automatic t_defer;
    logic [7:0] d;
    set_len(14'd4, 2'b01);
    command(2'b11);
    set_len(14'd6, 2'b11);
    command(2'b11);
    pulse(2); chk_out("R10 old mode kept", 1'b0);
    pulse(2); chk_out("R10 high after switch", 1'b1);
    chk_status("R10 tc then running", 8'hC0);
    pulse(4); chk_out("R10 new length high", 1'b1);
    pulse(1); chk_out("R10 new mode pulse", 1'b0);
    pulse(1); chk_out("R10 new reload", 1'b1);
    command(2'b01);
    rd(3'd0, d);
  endtask

  task automatic t_reset_keep;
    logic [7:0] d;
    set_len(14'd4, 2'b10);
    command(2'b11);
    pulse(1);
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(2);
    chk_out("R12 out high after reset", 1'b1);
    chk_status("R12 stopped by reset", 8'h00);
    rd(3'd4, d); chk("R12 length kept", d, 8'h04);
    rd(3'd5, d); chk("R12 mode kept", d, 8'h80);
    command(2'b11);
    pulse(3); chk_out("R12 kept config used", 1'b0);
    pulse(1); chk_out("R12 one-shot ends", 1'b1);
    chk_status("R12 stopped at tc", 8'h40);
  endtask

  task automatic t_min_len;
    set_len(14'd1, 2'b11);
    command(2'b11);
    pulse(1); chk_out("R13 low after 1 of 2", 1'b0);
    pulse(1); chk_out("R13 high at reload", 1'b1);
    pulse(1); chk_out("R13 low again", 1'b0);
    command(2'b01);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_square();
    t_half_low();
    t_one_pulse();
    t_pulse_reload();
    t_stop();
    t_stop_tc();
    t_defer();
    t_reset_keep();
    t_min_len();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule